// File: doc/BRIEF.md
# Round-Robin Grant-Passing Bus Arbiter

This block shares one bus among four masters by circulating a single offer around a ring. Each cycle exactly one device sees its grant line high. If that device is not requesting, the offer moves to the next device in ring order on the following clock. If it is requesting, it becomes the bus owner. The offer then stays with it for as long as it keeps its request high.

When the owner drops its request, the bus is released. An encoder turns the owner's grant back into an index, and on the next clock the offer pointer is loaded with the position just after that owner. The device after the one that actually used the bus therefore gets the first chance in the next round, even if the offer first reached a different device. With no requests pending, the offer keeps circulating, so a new request is served after at most one trip round the ring plus whatever tenure the current owner has left. All pins are plain control and status signals: there is no data path and no handshake at the edge.

Top module: `rr_pass_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, every grant line and `busy_o` are low. The first cycle after reset offers the bus to device 0 (`gnt_o` = 4'b0001).
- R2: Outside reset, exactly one bit of `gnt_o` is high, and bit i is the offer to device i.
- R3: If the offered device i has its request low in a cycle, the offer moves to device (i+1) mod 4 on the next clock.
- R4: If the offered device has its request high in a cycle, `busy_o` is high in that cycle and the offer stays on the same device on the next clock.
- R5: An owner keeps its grant for as long as its request stays high, whatever the other request lines do.
- R6: In the cycle the owner drops its request, its grant is still shown and `busy_o` is low. On the next clock the offer goes to owner+1 (mod 4), ahead of any other waiting device.
- R7: With the bus idle, a device that holds its request high is granted within 4 cycles.
- R8: `busy_o` is high exactly in the cycles in which the granted device has its request high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 4 | Request line per device, bit i for device i |
| gnt_o | output | 4 | One-hot offer/grant, bit i for device i |
| busy_o | output | 1 | High while the granted device holds its request |

## Verification
The assertions assume that the request lines change only between clock edges and are never X outside reset. They also assume that a device lowering its request means it has finished with the bus, so no tenure rules are checked beyond the request level itself. The stimulus changes `req_i` just after each rising edge and samples outputs well before the next one. It drives only defined values, so the pointer model in the bench and the properties see the same settled inputs.

// File: rtl/rr_pkg.sv
package rr_pkg;
  // Rotate a one-hot vector by one position towards the higher index.
  function automatic logic [3:0] rot_up4(input logic [3:0] v);
    return {v[2:0], v[3]};
  endfunction
endpackage

// File: rtl/rr_idx_decoder.sv
module rr_idx_decoder #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         en,
  input  logic [W-1:0] idx,
  output logic [N-1:0] onehot
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign onehot[i] = en && (idx == W'(i));
  end
endmodule

// File: rtl/rr_onehot_encoder.sv
module rr_onehot_encoder #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] onehot,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = idx | W'(i);
    end
  end
endmodule

// File: rtl/rr_offer_ring.sv
module rr_offer_ring #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         reload,
  input  logic [W-1:0] reload_idx,
  output logic [W-1:0] ptr
);
  logic [W-1:0] ptr_q;
  logic [W-1:0] ptr_d;

  always_comb begin
    if (hold)        ptr_d = ptr_q;
    else if (reload) ptr_d = W'(reload_idx + 1'b1);
    else             ptr_d = W'(ptr_q + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R1: reset lands the pointer on device 0
  p_ptr_reset_r1: assert property (@(posedge clk) rst |=> (ptr_q == '0));
  // R4: an accepted offer keeps the pointer in place
  p_hold_ptr_r4: assert property (@(posedge clk) disable iff (rst)
    hold |=> (ptr_q == $past(ptr_q)));
endmodule

// File: rtl/rr_pass_arbiter.sv
module rr_pass_arbiter #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         busy_o
);
  logic [W-1:0] ptr;
  logic [W-1:0] owner_idx;
  logic [W-1:0] owner_q;
  logic         owned_q;
  logic [N-1:0] gnt;
  logic         busy;
  logic         release_now;

  rr_idx_decoder #(.N(N)) u_dec (
    .en     (!rst),
    .idx    (ptr),
    .onehot (gnt)
  );

  rr_onehot_encoder #(.N(N)) u_enc (
    .onehot (gnt & req_i),
    .idx    (owner_idx)
  );

  assign busy        = |(gnt & req_i);
  assign release_now = owned_q && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      owned_q <= 1'b0;
      owner_q <= '0;
    end else begin
      owned_q <= busy;
      if (busy) owner_q <= owner_idx;
    end
  end

  rr_offer_ring #(.N(N)) u_ring (
    .clk        (clk),
    .rst        (rst),
    .hold       (busy),
    .reload     (release_now),
    .reload_idx (owner_q),
    .ptr        (ptr)
  );

  assign gnt_o  = gnt;
  assign busy_o = busy;

  // R1: nothing granted while in reset
  p_no_grant_in_reset_r1: assert property (@(posedge clk) rst |-> (gnt_o == '0 && !busy_o));
  // R2: a single offer outside reset
  p_single_offer_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(gnt_o) == 1);
  // R3: an unused offer moves one step round the ring
  p_pass_on_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !owned_q) |=> (gnt_o == {$past(gnt_o[N-2:0]), $past(gnt_o[N-1])}));
  // R5: the owner keeps the grant while requesting
  p_owner_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> $stable(gnt_o));
  // R6: after release the offer starts at the device after the owner
  p_next_after_owner_r6: assert property (@(posedge clk) disable iff (rst)
    release_now |=> (ptr == W'($past(owner_q) + 1'b1)));
  // R8: busy means the granted device is requesting
  p_busy_match_r8: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> ($countones(gnt_o & req_i) == 1));
endmodule

// File: tb/sim_rr_pass_arbiter.sv
module sim_rr_pass_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = '0;
  logic [3:0] gnt;
  logic       busy;
  int         errs = 0;
  int         checks = 0;
  int         exp_ptr = 0;

  always #10 clk = ~clk;

  rr_pass_arbiter u0 (.clk(clk), .rst(rst), .req_i(req), .gnt_o(gnt), .busy_o(busy));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Advance one clock, apply new requests, then check against the ring model.
  task automatic tick(input logic [3:0] r);
    @(posedge clk);
    #2 req = r;
    #6;
    chk("R2 grant follows offer model", 32'(gnt), 32'(4'b0001 << exp_ptr));
    chk("R8 busy matches granted request", 32'(busy), 32'(r[exp_ptr]));
    if (!r[exp_ptr]) exp_ptr = (exp_ptr + 1) % 4;
  endtask

  task automatic t_reset();
    rst = 1'b1; req = 4'b1111;
    repeat (2) @(posedge clk);
    #8;
    chk("R1 no grant during reset", 32'(gnt), 32'h0);
    chk("R1 busy low during reset", 32'(busy), 32'h0);
    @(posedge clk);
    #2 rst = 1'b0; req = 4'b0000;
    #6;
    exp_ptr = 0;
    chk("R1 first offer to device 0", 32'(gnt), 32'h1);
    exp_ptr = 1;
  endtask

  task automatic t_circulate();
    for (int k = 0; k < 8; k++) begin
      tick(4'b0000);
      chk("R3 offer steps round ring", 32'(busy), 32'h0);
    end
  endtask

  task automatic t_take_latency();
    int waited = 0;
    // Offer is at exp_ptr; ask for the device just passed: worst-case wait.
    int who = (exp_ptr + 3) % 4;
    tick(4'b0000);
    who = (exp_ptr + 3) % 4;
    while (waited < 6) begin
      tick(4'(1 << who));
      waited++;
      if (busy) break;
    end
    chk("R7 idle-bus grant within 4 cycles", 32'(waited <= 4), 32'h1);
    chk("R4 taker sees its grant", 32'(gnt), 32'(1 << who));
    tick(4'(1 << who));
    chk("R4 offer stays on taker", 32'(gnt), 32'(1 << who));
    tick(4'b0000);
  endtask

  task automatic t_hold_and_release();
    // Walk the offer to device 2 and let it take the bus.
    while (exp_ptr != 2) tick(4'b0000);
    tick(4'b0100);
    chk("R4 device 2 takes bus", 32'(busy), 32'h1);
    for (int k = 0; k < 5; k++) begin
      tick(4'b1111);
      chk("R5 owner keeps grant with others waiting", 32'(gnt), 32'h4);
    end
    tick(4'b1011);
    chk("R6 release cycle still shows owner", 32'(gnt), 32'h4);
    chk("R6 release cycle busy low", 32'(busy), 32'h0);
    tick(4'b1011);
    chk("R6 next round starts after owner", 32'(gnt), 32'h8);
    chk("R6 device 3 served before device 0", 32'(busy), 32'h1);
    tick(4'b0011);
    chk("R6 device 3 release", 32'(busy), 32'h0);
    tick(4'b0011);
    chk("R6 device 0 follows device 3", 32'(gnt), 32'h1);
    tick(4'b0000);
  endtask

  task automatic t_midreset();
    tick(4'b0010);
    @(posedge clk);
    #2 rst = 1'b1;
    @(posedge clk);
    #8;
    chk("R1 mid-run reset clears grant", 32'(gnt), 32'h0);
    @(posedge clk);
    #2 rst = 1'b0; req = 4'b0000;
    #6;
    chk("R1 pointer back at device 0", 32'(gnt), 32'h1);
    exp_ptr = 1;
    tick(4'b0000);
  endtask

  initial begin
    #(20 * 20000);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_circulate();
    t_take_latency();
    t_hold_and_release();
    t_midreset();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule